// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that can carry a transfer on every clock, whether that transfer is a read or a write. Address, control and byte enables are registered on the rising clock edge. Write data follows its address by a fixed delay, so a read issued after a write never collides with that write's data on the bus. A static mode input picks one of two timings. In flow-through mode, read data appears in the cycle right after the command edge and write data is taken one edge later. In pipelined mode, read data passes through an output register and appears one cycle later, and write data is taken two edges after its address.

Four-beat bursts are started by a load cycle and continued with an advance input. Only the two low address bits step, in either linear or interleaved order. A read that targets a word whose write data has not yet reached the array returns the new bytes merged with the stored ones. The block drives read data on a separate output with a drive-enable. The host masks that enable asynchronously with an output-enable input or a sleep input.

Top module: `nbt_sram`

## Requirements
- R1: A load cycle (adv_i=0) selects the device only when cs0_ni=0, cs1_i=1 and cs2_ni=0. Any other combination is a deselect: it writes nothing and produces no read-data cycle.
- R2: In flow-through mode (flow_i=1), a read loaded or advanced at edge n puts the word on dq_o, with dq_oe_o=1, between edge n and edge n+1.
- R3: In pipelined mode (flow_i=0), a read captured at edge n puts the word on dq_o, with dq_oe_o=1, between edge n+1 and edge n+2.
- R4: Write data is sampled from dq_i one edge after the write's address in flow-through mode and two edges after it in pipelined mode. Byte k occupies bits 9k+8..9k and is written only when bw_ni[k]=0. Bytes whose enable is high keep their old value.
- R5: Reads and writes may alternate on consecutive clocks with no idle cycle, and every read returns the data of all earlier writes.
- R6: adv_i=1 continues the previous operation (read, write or deselect) at the next burst address. The upper address bits keep the value from the load cycle. The low two bits are (base+k) mod 4 when burst_lin_i=1 and base XOR k when burst_lin_i=0, where k is the beat number, counted modulo 4.
- R7: A read whose target word still has write data pending in the late-write pipeline returns that pending data, merged byte by byte with the stored word.
- R8: dq_oe_o is high only in read-data cycles. It stays low during write-data cycles and deselect cycles.
- R9: oe_ni=1 forces dq_oe_o low combinationally, whatever the synchronous state.
- R10: While sleep_i=1, no command is accepted, no write data is committed, and dq_oe_o is low.
- R11: While rst_ni=0, dq_oe_o is low and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_i | input | 1 | Static mode: 1 flow-through, 0 pipelined |
| burst_lin_i | input | 1 | Static burst order: 1 linear, 0 interleaved |
| cs0_ni | input | 1 | Chip enable, active low |
| cs1_i | input | 1 | Chip enable, active high |
| cs2_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1 advance burst, 0 load new command |
| we_ni | input | 1 | Load cycle: 0 write, 1 read |
| bw_ni | input | NUM_BYTES | Per-byte write enables, active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | NUM_BYTES*BYTE_W | Write data bus |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request, active high |
| dq_o | output | NUM_BYTES*BYTE_W | Read data bus |
| dq_oe_o | output | 1 | Read data drive enable |

## Verification
Suppose the late-write stage sits in the wrong place. Then a write commits the bus word from the wrong cycle, and the next read of that address shows corrupt bytes one or two cycles after the read command. A lost or stale forwarding path shows up at once in pipelined mode: a read issued right after a write to the same word returns the old bytes. A wrong burst counter sends later beats to neighbouring words, which shows on the first advanced read. A wrong drive-enable state shows on dq_oe_o in the very cycle it occurs, during write-data or deselect cycles.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address bits for burst beat k
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input logic       lin);
    return lin ? (base + beat) : (base ^ beat);
  endfunction

endpackage

// File: rtl/nbt_cmd_burst.sv
module nbt_cmd_burst
  import nbt_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sleep_i,
  input  logic                 lin_i,
  input  logic                 cs0_ni,
  input  logic                 cs1_i,
  input  logic                 cs2_ni,
  input  logic                 adv_i,
  input  logic                 we_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  output op_e                  op_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_BYTES-1:0] be_o
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nx;
  logic              sel;

  always_comb begin
    sel    = !cs0_ni && cs1_i && !cs2_ni;
    cnt_nx = cnt_q + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      addr_o <= '0;
      be_o   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (sleep_i) begin
      op_o <= OP_IDLE;
    end else if (adv_i) begin
      cnt_q  <= cnt_nx;
      addr_o <= {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_nx, lin_i)};
      be_o   <= ~bw_ni;
    end else begin
      op_o   <= !sel ? OP_IDLE : (we_ni ? OP_RD : OP_WR);
      base_q <= addr_i;
      addr_o <= addr_i;
      cnt_q  <= '0;
      be_o   <= ~bw_ni;
    end
  end

  a_r1_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !adv_i && (cs0_ni || !cs1_i || cs2_ni)) |=> (op_o == OP_IDLE));

  a_r6_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && adv_i) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  a_r6_beat_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && adv_i) |=> (addr_o[1:0] != $past(addr_o[1:0])));

  a_r10_sleep_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (op_o == OP_IDLE));

endmodule

// File: rtl/nbt_late_wr.sv
module nbt_late_wr
  import nbt_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flow_i,
  input  logic                 sleep_i,
  input  op_e                  op_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_BYTES-1:0] be_i,
  output logic                 wen_o,
  output logic [ADDR_W-1:0]    waddr_o,
  output logic [NUM_BYTES-1:0] wbe_o
);

  op_e                  op2_q;
  logic [ADDR_W-1:0]    addr2_q;
  logic [NUM_BYTES-1:0] be2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op2_q   <= OP_IDLE;
      addr2_q <= '0;
      be2_q   <= '0;
    end else begin
      op2_q   <= op_i;
      addr2_q <= addr_i;
      be2_q   <= be_i;
    end
  end

  // flow-through commits from stage 1, pipelined from stage 2
  always_comb begin
    if (flow_i) begin
      wen_o   = !sleep_i && (op_i == OP_WR);
      waddr_o = addr_i;
      wbe_o   = be_i;
    end else begin
      wen_o   = !sleep_i && (op2_q == OP_WR);
      waddr_o = addr2_q;
      wbe_o   = be2_q;
    end
  end

  a_r4_double_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_i && wen_o) |-> $past(op_i == OP_WR));

  a_r10_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !wen_o);

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                          clk_i,
  input  logic                          wen_i,
  input  logic [ADDR_W-1:0]             waddr_i,
  input  logic [NUM_BYTES-1:0]          wbe_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   wdata_i,
  input  logic [ADDR_W-1:0]             raddr_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   rdata_o
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (wen_i && wbe_i[b]) mem[waddr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/nbt_rd_out.sv
module nbt_rd_out
  import nbt_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flow_i,
  input  logic                          sleep_i,
  input  logic                          oe_ni,
  input  op_e                           op_i,
  input  logic [ADDR_W-1:0]             raddr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   rdata_i,
  input  logic                          wen_i,
  input  logic [ADDR_W-1:0]             waddr_i,
  input  logic [NUM_BYTES-1:0]          wbe_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   wdata_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   dq_o,
  output logic                          dq_oe_o
);

  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic [DATA_W-1:0] merged, out_q;
  logic              fwd_hit, drive_q, drive;

  // pending write lands on the same edge as the output register
  assign fwd_hit = !flow_i && wen_i && (waddr_i == raddr_i);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = (fwd_hit && wbe_i[b]) ?
        wdata_i[b*BYTE_W +: BYTE_W] : rdata_i[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= 1'b0;
      out_q   <= '0;
    end else begin
      drive_q <= (op_i == OP_RD) && !sleep_i;
      if (op_i == OP_RD) out_q <= merged;
    end
  end

  always_comb begin
    drive   = flow_i ? (op_i == OP_RD) : drive_q;
    dq_o    = flow_i ? rdata_i : out_q;
    dq_oe_o = drive && !oe_ni && !sleep_i;
  end

  a_r8_read_cycle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (flow_i ? (op_i == OP_RD) : $past(op_i == OP_RD)));

  a_r10_sleep_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  a_r9_oe_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flow_i,
  input  logic                          burst_lin_i,
  input  logic                          cs0_ni,
  input  logic                          cs1_i,
  input  logic                          cs2_ni,
  input  logic                          adv_i,
  input  logic                          we_ni,
  input  logic [NUM_BYTES-1:0]          bw_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   dq_i,
  input  logic                          oe_ni,
  input  logic                          sleep_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   dq_o,
  output logic                          dq_oe_o
);

  localparam int DATA_W = NUM_BYTES * BYTE_W;

  op_e                  op_s1;
  logic [ADDR_W-1:0]    addr_s1, waddr;
  logic [NUM_BYTES-1:0] be_s1, wbe;
  logic                 wen;
  logic [DATA_W-1:0]    rdata;

  nbt_cmd_burst #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_cmd (
    .clk_i, .rst_ni, .sleep_i, .lin_i(burst_lin_i),
    .cs0_ni, .cs1_i, .cs2_ni, .adv_i, .we_ni, .bw_ni, .addr_i,
    .op_o(op_s1), .addr_o(addr_s1), .be_o(be_s1)
  );

  nbt_late_wr #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_wr (
    .clk_i, .rst_ni, .flow_i, .sleep_i,
    .op_i(op_s1), .addr_i(addr_s1), .be_i(be_s1),
    .wen_o(wen), .waddr_o(waddr), .wbe_o(wbe)
  );

  nbt_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk_i, .wen_i(wen), .waddr_i(waddr), .wbe_i(wbe), .wdata_i(dq_i),
    .raddr_i(addr_s1), .rdata_o(rdata)
  );

  nbt_rd_out #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_rd (
    .clk_i, .rst_ni, .flow_i, .sleep_i, .oe_ni,
    .op_i(op_s1), .raddr_i(addr_s1), .rdata_i(rdata),
    .wen_i(wen), .waddr_i(waddr), .wbe_i(wbe), .wdata_i(dq_i),
    .dq_o, .dq_oe_o
  );

endmodule

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;
  localparam int AW = 6, NB = 4, BW = 9, DW = NB * BW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni, flow_i, burst_lin_i, cs0_ni, cs1_i, cs2_ni, adv_i, we_ni, oe_ni, sleep_i;
  logic [NB-1:0] bw_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe_o;

  nbt_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW)) dut_i (
    .clk_i(clk), .rst_ni, .flow_i, .burst_lin_i, .cs0_ni, .cs1_i, .cs2_ni,
    .adv_i, .we_ni, .bw_ni, .addr_i, .dq_i, .oe_ni, .sleep_i, .dq_o, .dq_oe_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [NB-1:0] known   [DEPTH];
  int            m_op;
  logic [AW-1:0] m_addr, m_base, p1_addr, p2_addr;
  logic [1:0]    m_cnt;
  logic [NB-1:0] p1_be, p2_be;
  bit            p1_wr, p2_wr, last_adv;

  function automatic logic [1:0] seq_lo(logic [1:0] b, logic [1:0] k, bit lin);
    return lin ? b + k : b ^ k;
  endfunction

  function automatic logic [DW-1:0] byte_mask(logic [NB-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*BW +: BW] = {BW{m[i]}};
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_op = 0; m_addr = '0; m_base = '0; m_cnt = '0;
    p1_wr = 0; p2_wr = 0; p1_addr = '0; p2_addr = '0; p1_be = '0; p2_be = '0;
    last_adv = 0;
  endtask

  // one clock: edge, then model update and checks at the falling edge
  task automatic step(string dtag);
    bit            sel, due_wr, prev_rd_ok, prev_fwd, prev_adv, exp_oe;
    logic [AW-1:0] due_addr, prev_addr;
    logic [NB-1:0] due_be;
    logic [DW-1:0] exp_d, mask;
    string         t_oe, t_d;
    @(posedge clk);
    @(negedge clk);
    due_wr   = flow_i ? p1_wr : p2_wr;
    due_addr = flow_i ? p1_addr : p2_addr;
    due_be   = flow_i ? p1_be : p2_be;
    prev_fwd = !flow_i && p2_wr && (p2_addr == m_addr) && (m_op == 1);
    prev_adv = last_adv;
    if (due_wr && !sleep_i)
      for (int b = 0; b < NB; b++)
        if (due_be[b]) begin
          ref_mem[due_addr][b*BW +: BW] = dq_i[b*BW +: BW];
          known[due_addr][b] = 1'b1;
        end
    prev_addr  = m_addr;
    prev_rd_ok = (m_op == 1) && !sleep_i;
    sel = !cs0_ni && cs1_i && !cs2_ni;
    if (sleep_i) m_op = 0;
    else if (adv_i) begin
      m_cnt  = m_cnt + 2'd1;
      m_addr = {m_base[AW-1:2], seq_lo(m_base[1:0], m_cnt, burst_lin_i)};
    end else begin
      m_op   = !sel ? 0 : (we_ni ? 1 : 2);
      m_base = addr_i; m_addr = addr_i; m_cnt = '0;
    end
    p2_wr = p1_wr; p2_addr = p1_addr; p2_be = p1_be;
    p1_wr = (m_op == 2); p1_addr = m_addr; p1_be = ~bw_ni;
    last_adv = adv_i && !sleep_i;
    if (flow_i) begin
      exp_oe = (m_op == 1) && !oe_ni && !sleep_i;
      exp_d  = ref_mem[m_addr];
      mask   = byte_mask(known[m_addr]);
    end else begin
      exp_oe = prev_rd_ok && !oe_ni && !sleep_i;
      exp_d  = ref_mem[prev_addr];
      mask   = byte_mask(known[prev_addr]);
    end
    t_oe = dtag != "" ? dtag : oe_ni ? "R9" : sleep_i ? "R10" : "R8";
    t_d  = dtag != "" ? dtag : prev_fwd ? "R7" :
           ((flow_i ? last_adv : prev_adv) ? "R6" : (flow_i ? "R2" : "R3"));
    chk(dq_oe_o == exp_oe, t_oe, "dq_oe_o", DW'(dq_oe_o), DW'(exp_oe));
    if (exp_oe) chk((dq_o & mask) == (exp_d & mask), t_d, "dq_o", dq_o & mask, exp_d & mask);
  endtask

  task automatic drive(bit adv, bit sel_ok, int bad, bit we_n, logic [NB-1:0] bw,
                       logic [AW-1:0] a, bit oe_n, bit slp);
    adv_i  = adv;
    cs0_ni = !sel_ok && bad == 0;
    cs1_i  = !(!sel_ok && bad == 1);
    cs2_ni = !sel_ok && bad == 2;
    we_ni  = we_n; bw_ni = bw; addr_i = a; oe_ni = oe_n; sleep_i = slp;
    dq_i   = DW'({$urandom(), $urandom()});
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NB-1:0] bw, string tag);
    drive(0, 1, 0, 0, bw, a, 0, 0); step(tag);
  endtask
  task automatic rd(logic [AW-1:0] a, string tag);
    drive(0, 1, 0, 1, '1, a, 0, 0); step(tag);
  endtask
  task automatic nop(string tag);
    drive(0, 0, 0, 1, '1, '0, 0, 0); step(tag);
  endtask
  task automatic adv(string tag);
    drive(1, 1, 0, 1, '0, '0, 0, 0); step(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    drive(0, 0, 0, 1, '1, '0, 0, 0);
    repeat (3) @(negedge clk);
    chk(dq_oe_o == 1'b0, "R11", "dq_oe_o in reset", DW'(dq_oe_o), '0);
    model_reset();
    rst_ni = 1'b1;
  endtask

  task automatic directed();
    // R4 partial byte write
    wr(6'd20, 4'h0, "R4"); wr(6'd20, 4'b1101, "R4"); nop("R4"); nop("R4");
    rd(6'd20, "R4"); nop("R4"); nop("R4");
    // R5 alternating, no idle
    wr(6'd8, 4'h0, "R5"); rd(6'd8, "R5"); wr(6'd9, 4'h0, "R5"); rd(6'd9, "R5");
    wr(6'd8, 4'b0110, "R5"); rd(6'd9, "R5"); rd(6'd8, "R5"); nop("R5"); nop("R5"); nop("R5");
    // R7 read right behind write
    wr(6'd30, 4'h0, "R7"); rd(6'd30, "R7"); nop("R7"); wr(6'd30, 4'b1010, "R7"); rd(6'd30, "R7");
    nop("R7"); nop("R7");
    // R6 four-beat burst write then read
    wr(6'd13, 4'h0, "R6"); adv("R6"); adv("R6"); adv("R6"); nop("R6"); nop("R6");
    rd(6'd13, "R6"); adv("R6"); adv("R6"); adv("R6"); nop("R6"); nop("R6"); nop("R6");
    // R1 deselected cycles
    wr(6'd40, 4'h0, "R1"); nop("R1"); nop("R1");
    for (int b = 0; b < 3; b++) begin drive(0, 0, b, 0, 4'h0, 6'd40, 0, 0); step("R1"); end
    drive(0, 0, 1, 1, '1, 6'd40, 0, 0); step("R1"); nop("R1"); nop("R1");
    rd(6'd40, "R1"); nop("R1"); nop("R1");
    // R10 sleep blocks access
    drive(0, 1, 0, 0, 4'h0, 6'd40, 0, 1); step("R10");
    drive(0, 1, 0, 1, '1, 6'd40, 0, 1); step("R10");
    nop("R10"); nop("R10"); rd(6'd40, "R10"); nop("R10"); nop("R10");
    // R9 output enable mask
    drive(0, 1, 0, 1, '1, 6'd20, 1, 0); step("R9");
    drive(0, 0, 0, 1, '1, '0, 1, 0); step("R9"); nop("R9");
  endtask

  task automatic rand_cycle();
    bit            a_adv, sel, we_n, oe_n, slp;
    int            bad;
    logic [NB-1:0] bw;
    logic [AW-1:0] a;
    a_adv = $urandom_range(0, 2) == 0;
    sel   = $urandom_range(0, 7) != 0;
    bad   = $urandom_range(0, 2);
    we_n  = $urandom_range(0, 1) == 1;
    bw    = NB'($urandom());
    a     = ($urandom_range(0, 3) == 0) ? AW'($urandom()) : AW'($urandom_range(0, 15));
    oe_n  = $urandom_range(0, 15) == 0;
    slp   = $urandom_range(0, 31) == 0;
    drive(a_adv, sel, bad, we_n, bw, a, oe_n, slp);
    step("");
  endtask

  initial begin
    void'($urandom(32'd7011));
    for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; known[i] = '0; end
    rst_ni = 1'b0; flow_i = 1'b1; burst_lin_i = 1'b1;
    drive(0, 0, 0, 1, '1, '0, 0, 0);
    for (int ph = 0; ph < 4; ph++) begin
      flow_i      = (ph < 2);
      burst_lin_i = (ph % 2 == 0);
      do_reset();
      directed();
      for (int i = 0; i < 1500; i++) rand_cycle();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule